// File: doc/BRIEF.md
# Byte-Lane Write Strobe Controller

This block turns the active-low write controls of a synchronous static RAM word into one write strobe per byte lane. The default word is 36 bits, split into four 9-bit lanes that each carry a parity bit. The controls are sampled together with the address and write data on the rising clock edge. The strobes, address and data are held in flops. A write therefore needs no external pulse: the strobes are high for exactly the cycle after the controls were sampled, and the selected lanes are written at the end of that cycle.

There are two ways to write. Driving the global write low writes every lane, and the lane enables are then ignored. If global write is high, driving the byte-write enable low writes only the lanes whose own lane controls are low. If both are high, the cycle is a read and no strobe fires. A small behavioural array sits behind the strobes, and it has a combinational read port so the stored lanes can be observed.

Top module: `bwe_ctrl`

## Requirements
- R1: While the reset input `rst_n` is low, every bit of `lane_we` is 0.
- R2: When `gw_n` is 0 at a rising edge, all bits of `lane_we` are 1 in the next cycle, whatever `bwe_n` and `bw_n` are.
- R3: When `gw_n` is 1 and `bwe_n` is 0 at a rising edge, `lane_we[n]` in the next cycle equals the inverse of the sampled `bw_n[n]`. Every one of the 16 lane patterns is allowed, including none and all.
- R4: When `gw_n` and `bwe_n` are both 1 at a rising edge, `lane_we` is all zeros in the next cycle, whatever `bw_n` is.
- R5: Lane n covers data bits 9n+8 down to 9n. When its strobe is high, those bits of the sampled `wdata` are stored at the sampled `addr`. They can be read on `rd_data` once the following edge has passed.
- R6: A lane whose strobe is low keeps its previous stored contents.
- R7: A strobe lasts one cycle. It falls after the next edge unless that edge samples another write that selects the same lane. Back-to-back writes are each applied in order.
- R8: `rd_data` shows the stored word at `rd_addr` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write select, active low |
| addr | input | ADDR_W | Write address |
| wdata | input | LANES*LANE_W | Write data |
| rd_addr | input | ADDR_W | Observation read address |
| lane_we | output | LANES | Registered per-lane write strobes, active high |
| rd_data | output | LANES*LANE_W | Stored word at rd_addr |

## Verification
The byte-write enable path is driven through all 16 lane patterns on one preloaded address. The stored word is then compared lane by lane, which separates correct lane placement and retention from swapped or stuck lanes. Global writes are applied with the lane controls both fully deasserted and mixed, to show that the override ignores them. Reads with every lane control asserted show that the lane controls alone cannot write. A back-to-back pair followed by an idle cycle tells a one-cycle strobe apart from a held one.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_LANES = 2'd1,
      WR_ALL   = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/bwe_lane_decode.sv
module bwe_lane_decode #(
   parameter int LANES = 4
) (
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] strobe_d
);
   import bwe_pkg::*;

   wr_kind_e kind;

   always_comb begin
      if (!gw_n)       kind = WR_ALL;
      else if (!bwe_n) kind = WR_LANES;
      else             kind = WR_NONE;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb begin
         unique case (kind)
            WR_ALL:   strobe_d[g] = 1'b1;
            WR_LANES: strobe_d[g] = ~bw_n[g];
            default:  strobe_d[g] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/bwe_strobe_reg.sv
module bwe_strobe_reg #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        strobe_d,
   input  logic [ADDR_W-1:0]       addr_d,
   input  logic [LANES*LANE_W-1:0] data_d,
   output logic [LANES-1:0]        strobe_q,
   output logic [ADDR_W-1:0]       addr_q,
   output logic [LANES*LANE_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= '0;
         addr_q   <= '0;
         data_q   <= '0;
      end else begin
         strobe_q <= strobe_d;
         addr_q   <= addr_d;
         data_q   <= data_d;
      end
   end
endmodule

// File: rtl/bwe_lane_array.sv
module bwe_lane_array #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/bwe_ctrl.sv
module bwe_ctrl #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES-1:0]        lane_we,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int WORD_W = LANES * LANE_W;

   initial begin
      if (LANES < 1 || LANES > 16) $error("LANES out of range");
      if (LANE_W < 1)              $error("LANE_W must be positive");
      if (ADDR_W < 1 || ADDR_W > 8) $error("ADDR_W out of range");
   end

   logic [LANES-1:0]  strobe_d;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] data_q;

   bwe_lane_decode #(.LANES(LANES)) u_dec (
      .gw_n     (gw_n),
      .bwe_n    (bwe_n),
      .bw_n     (bw_n),
      .strobe_d (strobe_d)
   );

   bwe_strobe_reg #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_d (strobe_d),
      .addr_d   (addr),
      .data_d   (wdata),
      .strobe_q (lane_we),
      .addr_q   (addr_q),
      .data_q   (data_q)
   );

   bwe_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_arr (
      .clk   (clk),
      .we    (lane_we),
      .waddr (addr_q),
      .wdata (data_q),
      .raddr (rd_addr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/bwe_ctrl_chk.sv
module bwe_ctrl_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             gw_n,
   input logic             bwe_n,
   input logic [LANES-1:0] bw_n,
   input logic [LANES-1:0] lane_we
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> lane_we == '0); // R1
   AST_GW_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(gw_n)) |-> lane_we == '1); // R2
   AST_LANE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(gw_n) && !$past(bwe_n)) |-> lane_we == ~$past(bw_n)); // R3
   AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(gw_n) && $past(bwe_n)) |-> lane_we == '0); // R4
endmodule

bind bwe_ctrl bwe_ctrl_chk #(.LANES(LANES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .gw_n    (gw_n),
   .bwe_n   (bwe_n),
   .bw_n    (bw_n),
   .lane_we (lane_we)
);

// File: tb/tb_bwe_ctrl.sv
module tb_bwe_ctrl;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int ADDR_W = 4;
   localparam int WW     = LANES * LANE_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gw_n = 1'b1, bwe_n = 1'b1;
   logic [LANES-1:0]  bw_n = '1;
   logic [ADDR_W-1:0] addr = '0, rd_addr = '0;
   logic [WW-1:0]     wdata = '0;
   logic [LANES-1:0]  lane_we;
   logic [WW-1:0]     rd_data;

   int checks = 0, errors = 0;
   logic [WW-1:0] model [1<<ADDR_W];

   always #10 clk = ~clk;

   bwe_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) dut (.*);

   task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [LANES-1:0] exp_strobe(logic g, logic b, logic [LANES-1:0] l);
      if (!g) return '1;
      if (!b) return ~l;
      return '0;
   endfunction

   function automatic logic [WW-1:0] merge(logic [WW-1:0] old, logic [WW-1:0] nw,
                                           logic [LANES-1:0] s);
      logic [WW-1:0] r = old;
      for (int i = 0; i < LANES; i++)
         if (s[i]) r[i*LANE_W +: LANE_W] = nw[i*LANE_W +: LANE_W];
      return r;
   endfunction

   // One write cycle followed by an idle cycle; checks strobe, drop and stored word.
   task automatic cycle(string req, logic g, logic b, logic [LANES-1:0] l,
                        logic [ADDR_W-1:0] a, logic [WW-1:0] d);
      logic [LANES-1:0] s = exp_strobe(g, b, l);
      @(negedge clk);
      gw_n = g; bwe_n = b; bw_n = l; addr = a; wdata = d; rd_addr = a;
      @(posedge clk); #1;
      chk(req, WW'(lane_we), WW'(s));
      @(negedge clk);
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
      model[a] = merge(model[a], d, s);
      @(posedge clk); #1;
      chk("R7 drop", WW'(lane_we), '0);
      chk({req, " R5 R6 array"}, rd_data, model[a]);
   endtask

   task automatic t_reset();
      #5;
      chk("R1 reset", WW'(lane_we), '0);
      repeat (2) @(posedge clk);
      #1 chk("R1 reset held", WW'(lane_we), '0);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic t_global();
      for (int a = 0; a < (1 << ADDR_W); a++)
         cycle("R2 preload", 1'b0, 1'b1, '1, ADDR_W'(a), {WW{1'b0}} | (WW'(a) * 36'h0_0401_1003));
      cycle("R2 gw over bwe", 1'b0, 1'b0, 4'b1010, 4'd3, 36'h1_2345_6789);
      cycle("R2 gw over lanes", 1'b0, 1'b0, 4'b0000, 4'd4, 36'hA_BCDE_F012);
   endtask

   task automatic t_lanes();
      for (int p = 0; p < (1 << LANES); p++) begin
         logic [WW-1:0] d;
         for (int i = 0; i < LANES; i++)
            d[i*LANE_W +: LANE_W] = LANE_W'(9'h100 | (p << 4) | i);
         cycle("R3 lane pattern", 1'b1, 1'b0, LANES'(p), 4'd7, d);
      end
   endtask

   task automatic t_read();
      cycle("R4 read ignores lanes", 1'b1, 1'b1, '0, 4'd7, 36'hF_FFFF_FFFF);
      cycle("R4 read idle", 1'b1, 1'b1, 4'b0110, 4'd3, 36'h0);
   endtask

   task automatic t_position();
      cycle("R5 lane0 only", 1'b1, 1'b0, 4'b1110, 4'd9, 36'hF_FFFF_FFFF);
      cycle("R5 lane3 only", 1'b1, 1'b0, 4'b0111, 4'd10, 36'h0);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      gw_n = 1'b1; bwe_n = 1'b0; bw_n = 4'b1100; addr = 4'd12; wdata = 36'h5_5555_5555; rd_addr = 4'd12;
      @(posedge clk); #1 chk("R7 first", WW'(lane_we), WW'(4'b0011));
      @(negedge clk);
      bw_n = 4'b0011; wdata = 36'hA_AAAA_AAAA;
      model[12] = merge(model[12], 36'h5_5555_5555, 4'b0011);
      @(posedge clk); #1 chk("R7 second", WW'(lane_we), WW'(4'b1100));
      chk("R7 first stored", rd_data, model[12]);
      @(negedge clk);
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
      model[12] = merge(model[12], 36'hA_AAAA_AAAA, 4'b1100);
      @(posedge clk); #1 chk("R7 strobe drops", WW'(lane_we), '0);
      chk("R7 second stored", rd_data, model[12]);
   endtask

   task automatic t_read_port();
      @(negedge clk);
      rd_addr = 4'd3; #1 chk("R8 comb read a3", rd_data, model[3]);
      rd_addr = 4'd7; #1 chk("R8 comb read a7", rd_data, model[7]);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_global();
            t_lanes();
            t_read();
            t_position();
            t_back_to_back();
            t_read_port();
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule